// File: doc/BRIEF.md
# Rotating Program-Counter / Address-Register Pair

This block generates memory addresses for a very small soft processor without an address multiplexer. Two registers form a ring. The first holds the program counter. The second, the address register, always drives the memory address. The program-counter value passes through an adder that adds zero or one and lands in the address register. At the same edge the old address-register value moves into the program-counter register. Each such move is called an exchange.

A two-bit sequencer steps every instruction through four phases:

- **Fetch (0):** the address register holds the instruction address.
- **First exchange (1):** the stored data pointer, plus an optional step, comes forward.
- **Data (2):** the address register holds the data address, and it may be overwritten with an address fetched as an operand.
- **Second exchange (3):** the instruction address plus one comes back, and the data address is parked in the program-counter register.

Fetch and data access therefore share one address output, and the pointer's post-increment costs nothing beyond the adder already in the ring.

Top module: `rotating_addr_pair`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both registers and the phase. From the next cycle `mem_addr` is 0 and `phase` is 0, so the first fetch is from address 0 with a data pointer of 0.
- R2: Phase codes are 0 = fetch, 1 = first exchange, 2 = data, 3 = second exchange. Phase 0 holds until `instr_start` is high at an edge. Phases 1, 2 and 3 advance one per cycle (1 to 2, 2 to 3, 3 to 0) whatever the inputs.
- R3: `mem_addr` is always the address register. During phase 0 it is the instruction address, and it keeps that value through phase 1.
- R4: The edge ending phase 1 loads the address register with the stored data pointer plus `inc_sel` (1 or 0, sampled in phase 1), modulo 2^W. It moves the instruction address into the program-counter register.
- R5: The edge ending phase 3 loads the address register with the parked instruction address plus one, modulo 2^W, whatever `inc_sel` is. The address shown in phase 3 becomes the data pointer for the next instruction.
- R6: With `ld_en` high in phase 2, the address register takes `ld_data` at the edge ending phase 2. `ld_en` has no effect in any other phase.
- R7: `inc_sel` has an effect only in phase 1.
- R8: All address arithmetic wraps at the width W (default 8). 255 + 1 gives 0 for both the instruction address and the data pointer.
- R9: `instr_start` has no effect outside phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_start | input | 1 | Begin an instruction (used in phase 0 only) |
| inc_sel | input | 1 | Step applied to the data pointer at the first exchange |
| ld_en | input | 1 | Overwrite the address register in the data phase |
| ld_data | input | W | Operand address to load |
| mem_addr | output | W | Memory address, always the address register |
| phase | output | 2 | Current phase of the instruction |

## Verification
A wrong register value in this ring cannot hide for long, because every value passes through `mem_addr` within one instruction. A bad swap or a wrong adder step shows on the port in the cycle right after the faulty edge. A corrupted parked value shows up one exchange later, as a wrong data address or a wrong next-fetch address. A wrong sequencer step shows on `phase` at once. It also moves every later address by one or more cycles against the reference model, which compares both outputs on every clock.

// File: rtl/addr_ring_pkg.sv
package addr_ring_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_XCH1  = 2'd1,
    PH_DATA  = 2'd2,
    PH_XCH2  = 2'd3
  } phase_e;

  // Sequencer stepping rule: only the fetch phase waits for a start strobe.
  function automatic phase_e phase_after(input phase_e cur, input logic go);
    phase_e nxt;
    case (cur)
      PH_FETCH: nxt = go ? PH_XCH1 : PH_FETCH;
      PH_XCH1:  nxt = PH_DATA;
      PH_DATA:  nxt = PH_XCH2;
      default:  nxt = PH_FETCH;
    endcase
    return nxt;
  endfunction

  // Step added by the ring adder on an exchange.
  function automatic logic exchange_step(input phase_e cur, input logic sel);
    return (cur == PH_XCH1) ? sel : 1'b1;
  endfunction

endpackage

// File: rtl/ring_phase_seq.sv
module ring_phase_seq
  import addr_ring_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   instr_start,
  input  logic   inc_sel,
  input  logic   ld_en,
  output phase_e phase,
  output logic   xch_fire,
  output logic   xch_step,
  output logic   load_fire
);

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phase_after(phase, instr_start);
  end

  assign xch_fire  = (phase == PH_XCH1) || (phase == PH_XCH2);
  assign xch_step  = exchange_step(phase, inc_sel);
  assign load_fire = (phase == PH_DATA) && ld_en;

  // R2: the sequence after fetch is fixed.
  a_r2_xch1_to_data: assert property (@(posedge clk) disable iff (rst)
    phase == PH_XCH1 |=> phase == PH_DATA);
  a_r2_data_to_xch2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DATA |=> phase == PH_XCH2);
  a_r2_xch2_to_fetch: assert property (@(posedge clk) disable iff (rst)
    phase == PH_XCH2 |=> phase == PH_FETCH);
  a_r2_fetch_wait: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && !instr_start) |=> phase == PH_FETCH);
  // R9: the strobe is not sampled outside fetch.
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_FETCH && instr_start) |=> phase != PH_XCH1);

endmodule

// File: rtl/ring_incr.sv
module ring_incr #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         inc,
  output logic [W-1:0] y
);

  logic [W-1:0] carry;
  assign carry[0] = inc;

  // Half-adder chain; the top carry is dropped so the sum wraps.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = a[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = a[i] & carry[i];
    end
  end

endmodule

// File: rtl/ring_regs.sv
module ring_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         xch_fire,
  input  logic         xch_step,
  input  logic         load_fire,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] addr_q
);

  logic [W-1:0] pc_q;
  logic [W-1:0] sum;

  ring_incr #(.W(W)) u_incr (
    .a   (pc_q),
    .inc (xch_step),
    .y   (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      addr_q <= '0;
    end else if (xch_fire) begin
      addr_q <= sum;
      pc_q   <= addr_q;
    end else if (load_fire) begin
      addr_q <= ld_data;
    end
  end

  // R4/R5: the old address register value lands in the program counter.
  a_r4_swap_back: assert property (@(posedge clk) disable iff (rst)
    xch_fire |=> pc_q == $past(addr_q));
  // R5/R8: a +1 exchange yields the counter plus one, wrapping.
  a_r5_plus_one: assert property (@(posedge clk) disable iff (rst)
    (xch_fire && xch_step) |=> addr_q == W'($past(pc_q) + W'(1)));
  // R4: a +0 exchange passes the counter through unchanged.
  a_r4_plus_zero: assert property (@(posedge clk) disable iff (rst)
    (xch_fire && !xch_step) |=> addr_q == $past(pc_q));
  // R6: an operand load replaces the address.
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    (load_fire && !xch_fire) |=> addr_q == $past(ld_data));
  // R3: with no exchange and no load both registers hold.
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!xch_fire && !load_fire) |=> ($stable(addr_q) && $stable(pc_q)));

endmodule

// File: rtl/rotating_addr_pair.sv
module rotating_addr_pair
  import addr_ring_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         instr_start,
  input  logic         inc_sel,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] mem_addr,
  output logic [1:0]   phase
);

  phase_e ph;
  logic   xch_fire;
  logic   xch_step;
  logic   load_fire;

  ring_phase_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .instr_start (instr_start),
    .inc_sel     (inc_sel),
    .ld_en       (ld_en),
    .phase       (ph),
    .xch_fire    (xch_fire),
    .xch_step    (xch_step),
    .load_fire   (load_fire)
  );

  ring_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .xch_fire  (xch_fire),
    .xch_step  (xch_step),
    .load_fire (load_fire),
    .ld_data   (ld_data),
    .addr_q    (mem_addr)
  );

  assign phase = ph;

  // R1: reset leaves address 0 at fetch.
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && phase == 2'd0));
  // R3: the fetch address survives into the first exchange phase.
  a_r3_fetch_held: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd0 |=> $stable(mem_addr));
  // R6: a load request outside the data phase changes nothing.
  a_r6_ld_ignored: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && ld_en) |=> $stable(mem_addr));

endmodule

// File: tb/sim_rotating_addr_pair.sv
`timescale 1ns/1ps
module sim_rotating_addr_pair;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst, instr_start, inc_sel, ld_en;
  logic [W-1:0] ld_data, mem_addr;
  logic [1:0] phase;

  int checks = 0, fails = 0;
  bit cmp_on = 0;
  int m_ph = 0, m_pc = 0, m_ar = 0;
  int exp_ins = 0, exp_ptr = 0;

  always #2.5 clk = ~clk;

  rotating_addr_pair #(.W(W)) u0 (
    .clk(clk), .rst(rst), .instr_start(instr_start), .inc_sel(inc_sel),
    .ld_en(ld_en), .ld_data(ld_data), .mem_addr(mem_addr), .phase(phase));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: an instruction pointer and a data pointer that trade places.
  always @(posedge clk) begin
    int t;
    if (rst) begin
      m_ph = 0; m_pc = 0; m_ar = 0;
    end else begin
      case (m_ph)
        0: if (instr_start) m_ph = 1;
        1: begin t = m_ar; m_ar = (m_pc + (inc_sel ? 1 : 0)) % M; m_pc = t; m_ph = 2; end
        2: begin if (ld_en) m_ar = int'(ld_data); m_ph = 3; end
        default: begin t = m_ar; m_ar = (m_pc + 1) % M; m_pc = t; m_ph = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 model mem_addr", int'(mem_addr), m_ar);
      chk("R2 model phase", int'(phase), m_ph);
    end
  end

  // One instruction with decoy values on inputs in phases where they must be ignored.
  task automatic do_instr(input bit inc, input bit ld, input logic [W-1:0] v);
    int a_fetch, a_data, a_park;
    instr_start = 1; inc_sel = ~inc; ld_en = 1; ld_data = 8'hA5;
    a_fetch = mem_addr;
    chk("R3 fetch address", a_fetch, exp_ins);
    @(negedge clk);
    chk("R3 address held in phase 1", int'(mem_addr), exp_ins);
    instr_start = 1; inc_sel = inc; ld_en = 1; ld_data = 8'h5A;
    @(negedge clk);
    a_data = mem_addr;
    chk("R4 data address", a_data, (exp_ptr + (inc ? 1 : 0)) % M);
    instr_start = 0; inc_sel = ~inc; ld_en = ld; ld_data = v;
    @(negedge clk);
    a_park = mem_addr;
    chk("R6 phase-3 address", a_park, ld ? int'(v) : (exp_ptr + (inc ? 1 : 0)) % M);
    instr_start = 1; inc_sel = 0; ld_en = 1; ld_data = 8'hC3;
    @(negedge clk);
    instr_start = 0; inc_sel = 0; ld_en = 0;
    chk("R5 next fetch address", int'(mem_addr), (exp_ins + 1) % M);
    chk("R9 back in fetch", int'(phase), 0);
    exp_ins = (exp_ins + 1) % M;
    exp_ptr = a_park;
  endtask

  initial begin
    rst = 1; instr_start = 0; inc_sel = 0; ld_en = 0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset address", int'(mem_addr), 0);
    chk("R1 reset phase", int'(phase), 0);
    cmp_on = 1;
    // R2/R6/R7: idle in fetch with noise on other inputs.
    inc_sel = 1; ld_en = 1; ld_data = 8'h77;
    repeat (4) @(negedge clk);
    chk("R2 fetch holds phase", int'(phase), 0);
    chk("R6 idle load ignored", int'(mem_addr), 0);
    inc_sel = 0; ld_en = 0;
    do_instr(1, 0, 0);        // pointer 0 -> 1
    do_instr(0, 1, 8'h40);    // load pointer 0x40
    do_instr(1, 0, 0);        // 0x41
    do_instr(0, 1, 8'hFF);
    do_instr(1, 0, 0);        // R8 pointer wraps 255 -> 0
    chk("R8 pointer wrap", exp_ptr, 0);
    for (int i = 0; i < 260; i++) do_instr(i[0], i % 7 == 3, 8'(i * 37));
    chk("R8 instruction wrap", exp_ins, (5 + 260) % M);
    // R1 mid-instruction reset.
    instr_start = 1; @(negedge clk); instr_start = 0; @(negedge clk);
    cmp_on = 0; rst = 1; @(negedge clk); rst = 0;
    chk("R1 reset in data phase addr", int'(mem_addr), 0);
    chk("R1 reset in data phase phase", int'(phase), 0);
    cmp_on = 1; exp_ins = 0; exp_ptr = 0;
    do_instr(0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule